// File: doc/BRIEF.md
# Block-Write Column Engine

This block holds one open row of a DRAM array as 512 registered words of 16 bits. It carries out block-write cycles on that row. One column cycle stores the contents of a color register into every enabled column of an aligned group of 4 or 8 columns. The group is found by dropping the low bits of the column address. The data lines act as a per-column enable mask, and a write-per-bit mask register can restrict which bit positions change. The block also performs ordinary single-column writes and has load cycles for the color register and the bit-mask register.

The row strobe's falling edge is a one-cycle pulse, `ras_fall`. When it occurs, the block samples the row-level controls: special function, write-per-bit and group width. These controls decide how every column cycle in that row is handled, until `ras_rise` closes the row. A column strobe pulse, `cas_fall`, takes the column address, a column-level special-function bit and the data lines, and acts on them at that clock edge. A combinational read port shows any stored word.

Top module: `blkwr_engine`

## Requirements
- R1: After synchronous reset the row is closed, the color register and bit-mask register are 0, and every stored word is 0.
- R2: With the narrow group width (`wide_sel`=0 at the row edge), column address bits 1:0 are ignored. Bits 8:2 pick the group starting at column {addr[8:2],2'b00}. Data bit i (i=0..3) enables column base+i, and data bits 15:4 have no effect.
- R3: With the wide group width (`wide_sel`=1), column address bits 2:0 are ignored. Bits 8:3 pick the group starting at {addr[8:3],3'b000}. Data bit i (i=0..7) enables column base+i, and data bits 15:8 have no effect.
- R4: A block write changes no column whose data bit is 0 and no column outside the addressed group.
- R5: When `wpb_sel` was 1 at the row edge, a write changes only the bit positions that are 1 in the bit-mask register. When it was 0, all 16 bits are written.
- R6: A column cycle in a row opened with `fn_sel`=1 and `wpb_sel`=0 and with `col_fn_sel`=1 loads the color register from the data lines. The register keeps that value until the next such load.
- R7: A column cycle in a row opened with `fn_sel`=1 and `wpb_sel`=1 and with `col_fn_sel`=1 loads the bit-mask register from the data lines, and it keeps that value until the next such load.
- R8: In a row opened with `fn_sel`=0, a column cycle writes the data lines into the single addressed column, gated as in R5.
- R9: A column strobe has no effect while the row is closed, and none in the cycle that carries `ras_fall`.
- R10: `rd_data` shows the word at `rd_addr` combinationally. A write made at a clock edge shows there from that edge on, so a read in the strobe's own cycle returns the old word.
- R11: `fn_sel`, `wpb_sel` and `wide_sel` are sampled only on `ras_fall`. Changing them while a row is open has no effect on later column cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ras_fall | input | 1 | Row strobe falling-edge pulse; opens the row and samples the row controls |
| ras_rise | input | 1 | Row strobe rising-edge pulse; closes the row |
| fn_sel | input | 1 | Row-level special-function select |
| wpb_sel | input | 1 | Row-level write-per-bit enable |
| wide_sel | input | 1 | Group width: 0 = 4 columns, 1 = 8 columns |
| cas_fall | input | 1 | Column strobe pulse; performs one column cycle |
| col_fn_sel | input | 1 | Column-level special-function select (register load vs block write) |
| col_addr | input | 9 | Column address |
| dq | input | 16 | Data lines: write data, column mask or register load value |
| rd_addr | input | 9 | Read port column address |
| rd_data | output | 16 | Stored word at `rd_addr` |
| color_q | output | 16 | Color register contents |
| mask_q | output | 16 | Bit-mask register contents |

## Verification
A read of a column and a block write into that same column can fall in one cycle. To provoke this, the bench points `rd_addr` at a column inside the target group and pulses `cas_fall`. It judges the read port twice: just after the inputs settle it must still show the old word, and after the next clock edge it must show the merged color. A second overlap is a row-open pulse and a column strobe in the same cycle. Here the bench checks that the whole array is unchanged.

// File: rtl/blkwr_pkg.sv
package blkwr_pkg;

    localparam int COL_W  = 9;
    localparam int WORD_W = 16;
    localparam int N_COLS = 1 << COL_W;
    localparam int MAX_GRP = 8;

    typedef enum logic [1:0] {
        OP_WRITE    = 2'd0,
        OP_BLOCK    = 2'd1,
        OP_LD_COLOR = 2'd2,
        OP_LD_MASK  = 2'd3
    } col_op_e;

    typedef struct packed {
        logic special;
        logic per_bit;
        logic wide;
    } row_ctl_t;

    function automatic col_op_e decode_op(row_ctl_t r, logic col_fn);
        if (!r.special)     return OP_WRITE;
        else if (!col_fn)   return OP_BLOCK;
        else if (r.per_bit) return OP_LD_MASK;
        else                return OP_LD_COLOR;
    endfunction

    function automatic logic in_group(logic [COL_W-1:0] c, logic [COL_W-1:0] a,
                                      logic wide, logic [MAX_GRP-1:0] cm);
        if (wide) return (c[COL_W-1:3] == a[COL_W-1:3]) && cm[c[2:0]];
        else      return (c[COL_W-1:2] == a[COL_W-1:2]) && cm[{1'b0, c[1:0]}];
    endfunction

    function automatic logic [WORD_W-1:0] merge_bits(logic [WORD_W-1:0] old_w,
                                                     logic [WORD_W-1:0] new_w,
                                                     logic [WORD_W-1:0] bm);
        return (old_w & ~bm) | (new_w & bm);
    endfunction

endpackage

// File: rtl/blkwr_ctrl.sv
module blkwr_ctrl
    import blkwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ras_fall,
    input  logic     ras_rise,
    input  logic     fn_sel,
    input  logic     wpb_sel,
    input  logic     wide_sel,
    input  logic     cas_fall,
    input  logic     col_fn_sel,
    output row_ctl_t ctl_q,
    output logic     col_go,
    output col_op_e  op
);
    logic row_open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            row_open_q <= 1'b0;
            ctl_q      <= '0;
        end else if (ras_fall) begin
            row_open_q <= 1'b1;
            ctl_q      <= '{special: fn_sel, per_bit: wpb_sel, wide: wide_sel};
        end else if (ras_rise) begin
            row_open_q <= 1'b0;
        end
    end

    always_comb begin
        col_go = cas_fall && row_open_q && !ras_fall;
        op     = decode_op(ctl_q, col_fn_sel);
    end

    // R11: row controls only move on a row-open pulse
    p_ctl_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !ras_fall |=> $stable(ctl_q));

    // R9: a closed row stays closed until a row-open pulse
    p_closed_stays_r9: assert property (@(posedge clk) disable iff (rst)
        (!row_open_q && !ras_fall) |=> !row_open_q);

endmodule

// File: rtl/blkwr_regs.sv
module blkwr_regs
    import blkwr_pkg::*;
#(
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          col_go,
    input  col_op_e       op,
    input  logic [WW-1:0] dq,
    output logic [WW-1:0] color_q,
    output logic [WW-1:0] mask_q
);
    logic ld_color, ld_mask;

    always_comb begin
        ld_color = col_go && (op == OP_LD_COLOR);
        ld_mask  = col_go && (op == OP_LD_MASK);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            color_q <= '0;
            mask_q  <= '0;
        end else begin
            if (ld_color) color_q <= dq;
            if (ld_mask)  mask_q  <= dq;
        end
    end

    p_color_load_r6: assert property (@(posedge clk) disable iff (rst)
        ld_color |=> color_q == $past(dq));
    p_color_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !ld_color |=> $stable(color_q));
    p_mask_load_r7: assert property (@(posedge clk) disable iff (rst)
        ld_mask |=> mask_q == $past(dq));
    p_mask_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !ld_mask |=> $stable(mask_q));

endmodule

// File: rtl/blkwr_array.sv
module blkwr_array
    import blkwr_pkg::*;
#(
    parameter int CW = COL_W,
    parameter int WW = WORD_W,
    localparam int NC = 1 << CW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          col_go,
    input  col_op_e       op,
    input  logic          wide,
    input  logic          per_bit,
    input  logic [CW-1:0] col_addr,
    input  logic [WW-1:0] dq,
    input  logic [WW-1:0] color_q,
    input  logic [WW-1:0] mask_q,
    input  logic [CW-1:0] rd_addr,
    output logic [WW-1:0] rd_data
);
    logic [WW-1:0] mem [NC];
    logic [NC-1:0] we;
    logic [WW-1:0] wdata, bmask;
    logic [MAX_GRP-1:0] cmask;

    always_comb begin
        wdata = (op == OP_BLOCK) ? color_q : dq;
        bmask = per_bit ? mask_q : '1;
        cmask = dq[MAX_GRP-1:0];
    end

    for (genvar c = 0; c < NC; c++) begin : g_col
        always_comb begin
            we[c] = col_go &&
                    (((op == OP_WRITE) && (col_addr == CW'(c))) ||
                     ((op == OP_BLOCK) && in_group(CW'(c), col_addr, wide, cmask)));
        end
        always_ff @(posedge clk) begin
            if (rst)        mem[c] <= '0;
            else if (we[c]) mem[c] <= merge_bits(mem[c], wdata, bmask);
        end
    end

    assign rd_data = mem[rd_addr];

    // R8: a normal column cycle touches exactly one column
    p_single_col_r8: assert property (@(posedge clk) disable iff (rst)
        (col_go && op == OP_WRITE) |-> $countones(we) == 1);
    // R2: narrow group enables exactly the set low four data bits
    p_narrow_span_r2: assert property (@(posedge clk) disable iff (rst)
        (col_go && op == OP_BLOCK && !wide) |-> $countones(we) == $countones(dq[3:0]));
    // R3: wide group enables exactly the set low eight data bits
    p_wide_span_r3: assert property (@(posedge clk) disable iff (rst)
        (col_go && op == OP_BLOCK && wide) |-> $countones(we) == $countones(dq[7:0]));
    // R9: no column enable without an accepted column cycle
    p_no_stray_r9: assert property (@(posedge clk) disable iff (rst)
        !col_go |-> we == '0);

endmodule

// File: rtl/blkwr_engine.sv
module blkwr_engine
    import blkwr_pkg::*;
#(
    parameter int CW = COL_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ras_fall,
    input  logic          ras_rise,
    input  logic          fn_sel,
    input  logic          wpb_sel,
    input  logic          wide_sel,
    input  logic          cas_fall,
    input  logic          col_fn_sel,
    input  logic [CW-1:0] col_addr,
    input  logic [WW-1:0] dq,
    input  logic [CW-1:0] rd_addr,
    output logic [WW-1:0] rd_data,
    output logic [WW-1:0] color_q,
    output logic [WW-1:0] mask_q
);
    row_ctl_t ctl_q;
    logic     col_go;
    col_op_e  op;

    blkwr_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .fn_sel(fn_sel), .wpb_sel(wpb_sel), .wide_sel(wide_sel),
        .cas_fall(cas_fall), .col_fn_sel(col_fn_sel),
        .ctl_q(ctl_q), .col_go(col_go), .op(op)
    );

    blkwr_regs #(.WW(WW)) u_regs (
        .clk(clk), .rst(rst), .col_go(col_go), .op(op), .dq(dq),
        .color_q(color_q), .mask_q(mask_q)
    );

    blkwr_array #(.CW(CW), .WW(WW)) u_array (
        .clk(clk), .rst(rst), .col_go(col_go), .op(op),
        .wide(ctl_q.wide), .per_bit(ctl_q.per_bit),
        .col_addr(col_addr), .dq(dq), .color_q(color_q), .mask_q(mask_q),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

endmodule

// File: tb/sim_blkwr_engine.sv
module sim_blkwr_engine;

    typedef struct packed {
        logic [1:0]  kind;
        logic        wide;
        logic        wpb;
        logic [8:0]  col;
        logic [15:0] dq;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 1'b0, 1'b0, 9'h000, 16'hA5C3},
        '{2'd1, 1'b0, 1'b0, 9'h013, 16'h000F},
        '{2'd1, 1'b1, 1'b0, 9'h02F, 16'h00A5},
        '{2'd3, 1'b0, 1'b1, 9'h000, 16'h0FF0},
        '{2'd1, 1'b0, 1'b1, 9'h102, 16'h0005},
        '{2'd2, 1'b0, 1'b0, 9'h000, 16'h1234},
        '{2'd1, 1'b1, 1'b1, 9'h1FF, 16'h0081},
        '{2'd0, 1'b0, 1'b0, 9'h007, 16'hBEEF},
        '{2'd0, 1'b0, 1'b1, 9'h007, 16'h0000},
        '{2'd1, 1'b1, 1'b0, 9'h000, 16'h0000},
        '{2'd1, 1'b0, 1'b0, 9'h0A1, 16'hFFF0},
        '{2'd1, 1'b1, 1'b0, 9'h1F8, 16'h00FF}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ras_fall = 0, ras_rise = 0, fn_sel = 0, wpb_sel = 0, wide_sel = 0;
    logic cas_fall = 0, col_fn_sel = 0;
    logic [8:0]  col_addr = '0, rd_addr = '0;
    logic [15:0] dq = '0;
    logic [15:0] rd_data, color_q, mask_q;

    logic [15:0] ref_mem [512];
    logic [15:0] ref_color = '0, ref_mask = '0;
    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    blkwr_engine u0 (
        .clk(clk), .rst(rst), .ras_fall(ras_fall), .ras_rise(ras_rise),
        .fn_sel(fn_sel), .wpb_sel(wpb_sel), .wide_sel(wide_sel),
        .cas_fall(cas_fall), .col_fn_sel(col_fn_sel), .col_addr(col_addr),
        .dq(dq), .rd_addr(rd_addr), .rd_data(rd_data),
        .color_q(color_q), .mask_q(mask_q)
    );

    function automatic logic [15:0] mrg(logic [15:0] o, logic [15:0] n, logic [15:0] b);
        return (o & ~b) | (n & b);
    endfunction

    task automatic check_val(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        int bad = -1;
        logic [15:0] act_w = '0;
        for (int c = 0; c < 512; c++) begin
            rd_addr = 9'(c);
            #0.1;
            if (bad < 0 && rd_data !== ref_mem[c]) begin
                bad = c;
                act_w = rd_data;
            end
        end
        checks++;
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s: column %0d actual %h expected %h", tag, bad, act_w, ref_mem[bad]);
        end
        check_val({tag, " color"}, color_q, ref_color);
        check_val({tag, " mask"}, mask_q, ref_mask);
    endtask

    task automatic row_open(logic sf, logic wpb, logic wide);
        ras_fall = 1; fn_sel = sf; wpb_sel = wpb; wide_sel = wide;
        @(negedge clk);
        ras_fall = 0;
    endtask

    task automatic row_close();
        ras_rise = 1;
        @(negedge clk);
        ras_rise = 0;
    endtask

    task automatic col_cycle(logic [8:0] a, logic csf, logic [15:0] d);
        cas_fall = 1; col_addr = a; col_fn_sel = csf; dq = d;
        @(negedge clk);
        cas_fall = 0;
    endtask

    // reference model of one accepted column cycle
    task automatic model_op(logic [1:0] kind, logic wide, logic wpb, logic [8:0] a, logic [15:0] d);
        logic [15:0] bm = wpb ? ref_mask : 16'hFFFF;
        case (kind)
            2'd0: ref_mem[a] = mrg(ref_mem[a], d, bm);
            2'd1: begin
                for (int i = 0; i < (wide ? 8 : 4); i++) begin
                    logic [8:0] c = wide ? {a[8:3], 3'(i)} : {a[8:2], 2'(i)};
                    if (d[i]) ref_mem[c] = mrg(ref_mem[c], ref_color, bm);
                end
            end
            2'd2: ref_color = d;
            default: ref_mask = d;
        endcase
    endtask

    task automatic do_op(logic [1:0] kind, logic wide, logic wpb_in, logic [8:0] a, logic [15:0] d);
        logic wpb = (kind == 2'd2) ? 1'b0 : (kind == 2'd3) ? 1'b1 : wpb_in;
        row_open(kind != 2'd0, wpb, wide);
        col_cycle(a, kind[1], d);
        model_op(kind, wide, wpb, a, d);
        row_close();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 512; c++) ref_mem[c] = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_all("R1 reset state");

        // table walk
        for (int v = 0; v < NV; v++) begin
            vec_t t = VECS[v];
            do_op(t.kind, t.wide, t.wpb, t.col, t.dq);
            case (t.kind)
                2'd0: check_all(t.wpb ? "R8/R5 normal write" : "R8 normal write");
                2'd1: check_all(t.wide ? (t.wpb ? "R3/R4/R5 wide block" : "R3/R4 wide block")
                                       : (t.wpb ? "R2/R4/R5 narrow block" : "R2/R4 narrow block"));
                2'd2: check_all("R6 color load");
                default: check_all("R7 mask load");
            endcase
        end

        // R9: strobe while row closed
        col_cycle(9'h050, 1'b0, 16'hDEAD);
        check_all("R9 closed row strobe");

        // R9: strobe in the same cycle as row open
        ras_fall = 1; fn_sel = 0; wpb_sel = 0; wide_sel = 0;
        cas_fall = 1; col_addr = 9'h051; col_fn_sel = 0; dq = 16'hCAFE;
        @(negedge clk);
        ras_fall = 0; cas_fall = 0;
        row_close();
        check_all("R9 same-cycle row open");

        // R10: read and block write of the same column in one cycle
        do_op(2'd2, 1'b0, 1'b0, 9'h0, 16'h7E81);
        row_open(1'b1, 1'b0, 1'b1);
        rd_addr = 9'h0C3;
        cas_fall = 1; col_addr = 9'h0C5; col_fn_sel = 0; dq = 16'h0008;
        #1;
        check_val("R10 same-cycle read old", rd_data, ref_mem[9'h0C3]);
        @(negedge clk);
        cas_fall = 0;
        model_op(2'd1, 1'b1, 1'b0, 9'h0C5, 16'h0008);
        check_val("R10 read after edge new", rd_data, 16'h7E81);
        row_close();

        // R11: row controls changed mid-row are ignored
        row_open(1'b1, 1'b0, 1'b0);
        fn_sel = 0; wide_sel = 1; wpb_sel = 1;
        col_cycle(9'h0E6, 1'b0, 16'h00F2);
        model_op(2'd1, 1'b0, 1'b0, 9'h0E6, 16'h00F2);
        row_close();
        check_all("R11 mid-row control change");

        // R6: color held across non-load cycles
        check_val("R6 color held", color_q, 16'h7E81);

        // random block writes in both modes, mixed with loads
        for (int n = 0; n < 240; n++) begin
            int r = $urandom_range(0, 9);
            logic [1:0] k = (r < 6) ? 2'd1 : (r < 7) ? 2'd0 : (r < 8) ? 2'd2 : 2'd3;
            do_op(k, 1'($urandom), 1'($urandom), 9'($urandom), 16'($urandom));
            if (n % 40 == 39) check_all("R2/R3/R4/R5 random mix");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule